// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This controller gathers interrupt sources onto ten vectors and gives each vector one of three priority levels. Each cycle it picks the most urgent requesting vector and raises a registered interrupt line to the CPU when that vector's level is strictly above every level already in service. When the CPU acknowledges, the controller latches the vector's entry address and marks the level as in service. A return-from-interrupt pulse releases the innermost level, so handlers nest only towards higher urgency.

Each vector has one select bit. The two lowest vectors choose between the top level and the low level. The other eight choose between the middle level and the low level. Requests are level-sensitive. The source must keep a request up until the acknowledge arrives, and it clears the request inside its handler.

Top module: `intc_vectored`

## Requirements
- R1: Vector v (0 to 9) has entry address 03h + 8h*v, so the addresses run 03h, 0Bh, ... up to 4Bh. After an acknowledge this address appears on `vec_addr_o`.
- R2: The level code is 0 for none, 1 for low, 2 for middle and 3 for top. If `lvl_sel_i[v]` is 0, the vector has level 1. If it is 1, the vector has level 3 for v of 0 or 1, and level 2 for v of 2 or more. After an acknowledge, `cur_lvl_o` shows the level of the vector that was taken.
- R3: Among vectors requesting at once, the one with the highest level is chosen. When levels are equal, the lowest vector index (lowest address) is chosen.
- R4: While a level is in service, a request whose level is equal to or lower than it keeps `irq_o` low, and `cur_lvl_o` stays unchanged.
- R5: A request whose level is strictly above the highest level in service raises `irq_o`. Acknowledging it raises `cur_lvl_o` to the new level.
- R6: A `reti_i` pulse ends service of the highest level in service. `cur_lvl_o` then falls to the next lower level still in service, or to 0.
- R7: Source bit s of `src_req_i` requests vector s/2. Each vector is the OR of its two sources.
- R8: `vec_addr_o` and `cur_lvl_o` change on an acknowledge only when `ack_i` is high while `irq_o` is high. `irq_o` is low in the cycle after such an acknowledge. An acknowledge while `irq_o` is low has no effect.
- R9: A request that drops before it is acknowledged clears `irq_o` one clock later and is never serviced.
- R10: After reset, `irq_o`, `vec_addr_o` and `cur_lvl_o` are all 0. `irq_o` rises on the first clock edge at which an eligible request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | 20 | Level-sensitive source requests, two per vector |
| lvl_sel_i | input | 10 | Per-vector level select (0 = low, 1 = upper level) |
| ack_i | input | 1 | CPU acknowledge pulse |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_addr_o | output | 8 | Entry address of the last acknowledged vector |
| cur_lvl_o | output | 2 | Highest level currently in service |

## Verification
The bench tries every pair of vectors under all four select combinations. It checks each pair against a model that computes level and index order arithmetically. A wrong tie-break, or a wrong mapping of the select bit to the top level, would return the wrong address. Every one of the twenty sources is raised alone, which catches a miswired OR group by its wrong entry address. A nested sequence checks that an equal-level request with a lower index stays blocked, that a top-level request preempts, and that returns unwind one level at a time. A controller that cleared all levels on return, or that allowed nesting at equal level, would show a wrong `cur_lvl_o` or a spurious `irq_o`. Acknowledges while `irq_o` is low, and requests that drop before acknowledge, must leave both outputs untouched.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LO   = 2'd1;
  localparam lvl_t LVL_MID  = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
  localparam int   NUM_LVL  = 3;
endpackage

// File: rtl/intc_src_merge.sv
module intc_src_merge #(
  parameter int NUM_VEC     = 10,
  parameter int SRC_PER_VEC = 2,
  localparam int NUM_SRC    = NUM_VEC * SRC_PER_VEC
) (
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_VEC-1:0] vec_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_grp
    assign vec_o[v] = |src_i[v*SRC_PER_VEC +: SRC_PER_VEC];
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_VEC = 10,
  parameter int NUM_TOP = 2,
  localparam int IDX_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] req_i,
  input  logic [NUM_VEC-1:0] sel_i,
  output logic               win_valid_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output lvl_t               win_lvl_o
);
  lvl_t vec_lvl [NUM_VEC];

  // Upper level is top-capable only for the lowest NUM_TOP vectors
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_lvl
    if (v < NUM_TOP) begin : g_top
      assign vec_lvl[v] = sel_i[v] ? LVL_TOP : LVL_LO;
    end else begin : g_mid
      assign vec_lvl[v] = sel_i[v] ? LVL_MID : LVL_LO;
    end
  end

  // Strict compare in ascending order keeps the lowest index on ties
  always_comb begin
    win_lvl_o = LVL_NONE;
    win_idx_o = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (req_i[v] && (vec_lvl[v] > win_lvl_o)) begin
        win_lvl_o = vec_lvl[v];
        win_idx_o = IDX_W'(v);
      end
    end
    win_valid_o = (win_lvl_o != LVL_NONE);
  end
endmodule

// File: rtl/intc_svc_tracker.sv
module intc_svc_tracker
  import intc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  lvl_t take_lvl_i,
  input  logic ret_i,
  output lvl_t cur_lvl_o
);
  logic [NUM_LVL-1:0] svc_q, svc_nxt, clr_mask;
  lvl_t               cur_q, cur_nxt;

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (svc_q[i]) clr_mask = NUM_LVL'(1) << i;
    end
    svc_nxt = svc_q;
    if (ret_i) svc_nxt = svc_nxt & ~clr_mask;
    if (take_i && (take_lvl_i != LVL_NONE)) svc_nxt[int'(take_lvl_i) - 1] = 1'b1;
    cur_nxt = LVL_NONE;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (svc_nxt[i]) cur_nxt = lvl_t'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q <= '0;
      cur_q <= LVL_NONE;
    end else begin
      svc_q <= svc_nxt;
      cur_q <= cur_nxt;
    end
  end

  assign cur_lvl_o = cur_q;
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
  import intc_pkg::*;
#(
  parameter int NUM_VEC     = 10,
  parameter int NUM_TOP     = 2,
  parameter int SRC_PER_VEC = 2,
  parameter int ADDR_W      = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8,
  localparam int NUM_SRC    = NUM_VEC * SRC_PER_VEC,
  localparam int IDX_W      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic [NUM_VEC-1:0] lvl_sel_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [1:0]         cur_lvl_o
);
  logic [NUM_VEC-1:0] vec_req;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  lvl_t               cur_lvl;
  logic               eligible, take;
  logic               irq_q;
  logic [IDX_W-1:0]   cand_idx_q;
  lvl_t               cand_lvl_q;
  logic [ADDR_W-1:0]  addr_q;

  intc_src_merge #(.NUM_VEC(NUM_VEC), .SRC_PER_VEC(SRC_PER_VEC)) u_merge (
    .src_i (src_req_i),
    .vec_o (vec_req)
  );

  intc_arbiter #(.NUM_VEC(NUM_VEC), .NUM_TOP(NUM_TOP)) u_arb (
    .req_i       (vec_req),
    .sel_i       (lvl_sel_i),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_lvl_o   (win_lvl)
  );

  assign take     = ack_i && irq_q;
  assign eligible = win_valid && (win_lvl > cur_lvl);

  intc_svc_tracker u_svc (
    .clk        (clk),
    .rst        (rst),
    .take_i     (take),
    .take_lvl_i (cand_lvl_q),
    .ret_i      (reti_i),
    .cur_lvl_o  (cur_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q      <= 1'b0;
      cand_idx_q <= '0;
      cand_lvl_q <= LVL_NONE;
      addr_q     <= '0;
    end else begin
      irq_q      <= eligible && !take;
      cand_idx_q <= win_idx;
      cand_lvl_q <= win_lvl;
      if (take) addr_q <= ADDR_W'(VEC_BASE) + ADDR_W'(cand_idx_q) * ADDR_W'(VEC_STEP);
    end
  end

  assign irq_o      = irq_q;
  assign vec_addr_o = addr_q;
  assign cur_lvl_o  = cur_lvl;
endmodule

// File: rtl/intc_vectored_chk.sv
module intc_vectored_chk #(
  parameter int NUM_VEC  = 10,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ack_i,
  input logic              reti_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [1:0]        cur_lvl_o
);
  // R8
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o) |=> !irq_o);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack_i && irq_o) |=> $stable(vec_addr_o));
  // R5
  nest_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o && !reti_i) |=> (cur_lvl_o > $past(cur_lvl_o)));
  // R4
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reti_i && !(ack_i && irq_o)) |=> $stable(cur_lvl_o));
  // R6
  reti_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !ack_i) |=> (cur_lvl_o <= $past(cur_lvl_o)));
  // R1
  addr_grid_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_addr_o == '0) ||
    ((int'(vec_addr_o) >= VEC_BASE) &&
     ((int'(vec_addr_o) - VEC_BASE) % VEC_STEP == 0) &&
     ((int'(vec_addr_o) - VEC_BASE) / VEC_STEP < NUM_VEC)));
endmodule

bind intc_vectored intc_vectored_chk #(
  .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst(rst), .ack_i(ack_i), .reti_i(reti_i),
  .irq_o(irq_o), .vec_addr_o(vec_addr_o), .cur_lvl_o(cur_lvl_o)
);

// File: tb/intc_vectored_bench.sv
module intc_vectored_bench;
  localparam int NV = 10;
  localparam int NS = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src = '0;
  logic [NV-1:0] sel = '0;
  logic          ack = 1'b0;
  logic          reti = 1'b0;
  logic          irq;
  logic [7:0]    addr;
  logic [1:0]    lvl;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  intc_vectored u_intc_vectored (
    .clk(clk), .rst(rst), .src_req_i(src), .lvl_sel_i(sel),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_addr_o(addr), .cur_lvl_o(lvl)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lvl(input int v, input bit s);
    if (!s) return 1;
    return (v < 2) ? 3 : 2;
  endfunction

  function automatic int exp_addr(input int v);
    return 3 + 8 * v;
  endfunction

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic do_ret();
    reti = 1'b1; step(1); reti = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R10 reset state
    chk(irq == 0, "R10 irq", irq, 0);
    chk(addr == 0, "R10 addr", addr, 0);
    chk(lvl == 0, "R10 lvl", lvl, 0);

    // R7 R1 R2: every source alone, both selects
    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < 2; b++) begin
        automatic int v = s / 2;
        sel = '0; sel[v] = b[0];
        src = '0; src[s] = 1'b1;
        step(1);
        chk(irq == 1, "R10 irq rise", irq, 1);
        do_ack();
        chk(irq == 0, "R8 irq drop", irq, 0);
        chk(addr == 8'(exp_addr(v)), "R7 R1 addr", addr, exp_addr(v));
        chk(lvl == 2'(exp_lvl(v, b[0])), "R2 level", lvl, exp_lvl(v, b[0]));
        src = '0;
        do_ret();
        chk(lvl == 0, "R6 ret", lvl, 0);
        step(1);
      end
    end

    // R3 all pairs, all select combinations
    for (int a = 0; a < NV; a++) begin
      for (int b = a + 1; b < NV; b++) begin
        for (int m = 0; m < 4; m++) begin
          automatic int la = exp_lvl(a, m[0]);
          automatic int lb = exp_lvl(b, m[1]);
          automatic int w = (lb > la) ? b : a;
          automatic int lw = (lb > la) ? lb : la;
          sel = '0; sel[a] = m[0]; sel[b] = m[1];
          src = '0; src[2*a+1] = 1'b1; src[2*b] = 1'b1;
          step(1);
          do_ack();
          chk(addr == 8'(exp_addr(w)), "R3 winner addr", addr, exp_addr(w));
          chk(lvl == 2'(lw), "R3 winner level", lvl, lw);
          src = '0;
          do_ret();
          step(1);
        end
      end
    end

    // R4 R5 R6 nesting
    sel = '0; src = '0;
    src[10] = 1'b1;                 // vector 5, low
    step(1); do_ack();
    chk(lvl == 1, "R5 first level", lvl, 1);
    src[10] = 1'b0;
    src[6] = 1'b1;                  // vector 3, low, lower index
    step(3);
    chk(irq == 0, "R4 equal blocked", irq, 0);
    chk(lvl == 1, "R4 level held", lvl, 1);
    sel[0] = 1'b1; src[0] = 1'b1;   // vector 0, top
    sel[4] = 1'b1; src[8] = 1'b1;   // vector 4, middle
    step(2);
    chk(irq == 1, "R5 higher irq", irq, 1);
    do_ack();
    chk(addr == 8'h03, "R5 nest addr", addr, 3);
    chk(lvl == 3, "R5 nest level", lvl, 3);
    src[0] = 1'b0;
    do_ret();
    chk(lvl == 1, "R6 unwind to low", lvl, 1);
    step(1);
    chk(irq == 1, "R5 middle pending", irq, 1);
    do_ack();
    chk(addr == 8'h23, "R5 middle addr", addr, 35);
    chk(lvl == 2, "R5 middle level", lvl, 2);
    src[8] = 1'b0;
    do_ret();
    chk(lvl == 1, "R6 back to low", lvl, 1);
    step(2);
    chk(irq == 0, "R4 low still blocked", irq, 0);
    do_ret();
    chk(lvl == 0, "R6 idle", lvl, 0);
    step(1);
    chk(irq == 1, "R4 released", irq, 1);
    do_ack();
    chk(addr == 8'h1B, "R3 released addr", addr, 27);
    src = '0;
    do_ret();
    step(1);

    // R8 ack with irq low is ignored
    do_ack();
    chk(lvl == 0, "R8 stray ack level", lvl, 0);
    chk(addr == 8'h1B, "R8 stray ack addr", addr, 27);

    // R9 dropped request
    sel = '0; sel[7] = 1'b1; src[15] = 1'b1;
    step(2);
    chk(irq == 1, "R9 raised", irq, 1);
    src = '0;
    step(1);
    chk(irq == 0, "R9 dropped", irq, 0);
    do_ack();
    chk(lvl == 0, "R9 not serviced", lvl, 0);
    chk(addr == 8'h1B, "R9 addr kept", addr, 27);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule